// File: doc/BRIEF.md
# Frame-Based Memory Request Quota Regulator

This block sits between a set of request sources and a memory network and bounds how many request packets each application may inject per time frame. Each request carries a 4-bit application identifier. In every cycle the block looks up the remaining budget for that identifier. If budget is left, the request is accepted and the budget drops by one. Otherwise the request is held until a later frame, even when the network is otherwise idle. Unused budget never passes to another application, so every application gets both a guaranteed minimum and a hard maximum per frame.

Frames have a fixed length in cycles and never end early. After reset the block sits in state `ST_WAIT_SYNC` with no grants. A single pulse on `frame_sync_i` takes it to `ST_RUN`. All regulators on the chip receive the same pulse, so their frame boundaries line up. `ST_RUN` has one self-transition, the frame boundary. In the last cycle of each frame, on the same edge, every application budget is reloaded from its quota register and the frame timer restarts. Quota and frame-length registers can be written at any time, but a new value is used only from the next frame boundary.

Top module: `bwreg_regulator`

## Requirements
- R1: After reset the block grants nothing (`req_ready_o`=0) until `frame_sync_i` is sampled high; the first frame begins in the cycle after that edge.
- R2: In `ST_RUN` a request is granted (`req_ready_o`=1) exactly when the budget of application `req_app_i` is nonzero. Each accepted request (`req_valid_i`=1 and `req_ready_o`=1) lowers that budget by one.
- R3: When one application requests in every cycle of a frame, it receives exactly as many grants as its quota held at the start of that frame.
- R4: An application with quota 0 receives no grant in any cycle of the frame, including when no other application is requesting.
- R5: A frame lasts exactly L cycles, where L is the frame length in force for that frame. The next frame starts only when the timer expires.
- R6: At every frame boundary all 16 application budgets are reloaded from their quota registers on the same clock edge. The reload replaces any decrement on that edge.
- R7: A write with `cfg_we_i`=1 updates a shadow value. `cfg_len_sel_i`=1 writes the frame length from `cfg_data_i[15:0]`. `cfg_len_sel_i`=0 writes the quota of application `cfg_app_i` from `cfg_data_i[7:0]`. Neither write changes budgets or frame length before the next frame boundary.
- R8: `frame_first_o` is high in the first cycle of each frame and low in all other cycles.
- R9: `req_hold_o` equals `req_valid_i` and not `req_ready_o`. `req_ready_o` does not depend on `req_valid_i`.
- R10: A frame length of 0 acts as a length of 1, so every cycle is a frame boundary.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync_i | input | 1 | Global pulse that starts the first frame |
| req_valid_i | input | 1 | Request present |
| req_app_i | input | 4 | Application identifier of the request |
| req_ready_o | output | 1 | Request granted this cycle |
| req_hold_o | output | 1 | Request present but held |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_len_sel_i | input | 1 | 1: write frame length, 0: write quota |
| cfg_app_i | input | 4 | Application whose quota is written |
| cfg_data_i | input | 16 | Write data |
| frame_first_o | output | 1 | First cycle of a frame |

## Verification
The assertions assume `req_app_i` and `cfg_app_i` are always known values, and that `frame_sync_i` matters only while the block waits after reset. The stimulus drives every input to a defined value in every cycle. It raises the sync pulse once and keeps it low from then on. Configuration writes, including length 0 and quota 0, arrive at random points in a frame, so the assertions on the next-boundary rule are exercised in the middle of frames as well as at the edges.

// File: rtl/bwreg_pkg.sv
package bwreg_pkg;
    typedef enum logic {
        ST_WAIT_SYNC = 1'b0,
        ST_RUN       = 1'b1
    } reg_state_t;
endpackage

// File: rtl/bwreg_frame_timer.sv
module bwreg_frame_timer #(
    parameter int LW      = 16,
    parameter int DEF_LEN = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          run_i,
    input  logic [LW-1:0] len_shadow_i,
    output logic          boundary_o,
    output logic          first_o
);
    logic [LW-1:0] len_q;
    logic [LW-1:0] tmr_q;
    logic [LW-1:0] eff_len;

    // zero length behaves as one cycle per frame
    assign eff_len    = (len_q == '0) ? LW'(1) : len_q;
    assign boundary_o = run_i && (tmr_q == eff_len - LW'(1));
    assign first_o    = run_i && (tmr_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LW'(DEF_LEN);
            tmr_q <= '0;
        end else if (start_i || boundary_o) begin
            len_q <= len_shadow_i;
            tmr_q <= '0;
        end else if (run_i) begin
            tmr_q <= tmr_q + LW'(1);
        end
    end

    // R5: the timer never passes the end of the frame in force
    p_timer_in_frame_r5: assert property (@(posedge clk) disable iff (!rst_n)
        run_i |-> (tmr_q < eff_len));

    // R5/R8: after a boundary the next cycle opens a fresh frame
    p_boundary_restart_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (boundary_o && run_i) |=> (tmr_q == '0));

    // R10: a frame length of zero makes every cycle a boundary
    p_zero_len_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && len_q == '0) |-> boundary_o);
endmodule

// File: rtl/bwreg_quota_bank.sv
module bwreg_quota_bank #(
    parameter int N_APP = 16,
    parameter int QW    = 8,
    parameter int AW    = $clog2(N_APP)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          q_we_i,
    input  logic [AW-1:0] q_addr_i,
    input  logic [QW-1:0] q_data_i,
    input  logic          reload_i,
    input  logic          take_i,
    input  logic [AW-1:0] app_i,
    output logic          avail_o
);
    logic [QW-1:0] shadow_q [N_APP];
    logic [QW-1:0] cnt_q    [N_APP];

    for (genvar g = 0; g < N_APP; g++) begin : g_app
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                shadow_q[g] <= '0;
                cnt_q[g]    <= '0;
            end else begin
                if (q_we_i && q_addr_i == AW'(g)) begin
                    shadow_q[g] <= q_data_i;
                end
                if (reload_i) begin
                    cnt_q[g] <= shadow_q[g];
                end else if (take_i && app_i == AW'(g)) begin
                    cnt_q[g] <= cnt_q[g] - QW'(1);
                end
            end
        end

        // R6: every budget is refilled from its quota register at the boundary
        p_reload_all_r6: assert property (@(posedge clk) disable iff (!rst_n)
            reload_i |=> (cnt_q[g] == $past(shadow_q[g])));

        // R2: an accepted request lowers its own budget by exactly one
        p_dec_by_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
            (!reload_i && take_i && app_i == AW'(g)) |=> (cnt_q[g] == $past(cnt_q[g]) - QW'(1)));

        // R7: budgets move only through grants or reloads, never through writes
        p_cfg_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
            (!reload_i && !(take_i && app_i == AW'(g))) |=> $stable(cnt_q[g]));
    end

    assign avail_o = (cnt_q[app_i] != '0);

    // R2/R4: a request is never taken against an empty budget
    p_no_take_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> (cnt_q[app_i] != '0));
endmodule

// File: rtl/bwreg_regulator.sv
module bwreg_regulator #(
    parameter int N_APP   = 16,
    parameter int QW      = 8,
    parameter int DW      = 16,
    parameter int DEF_LEN = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     frame_sync_i,
    input  logic                     req_valid_i,
    input  logic [$clog2(N_APP)-1:0] req_app_i,
    output logic                     req_ready_o,
    output logic                     req_hold_o,
    input  logic                     cfg_we_i,
    input  logic                     cfg_len_sel_i,
    input  logic [$clog2(N_APP)-1:0] cfg_app_i,
    input  logic [DW-1:0]            cfg_data_i,
    output logic                     frame_first_o
);
    import bwreg_pkg::*;

    localparam int AW = $clog2(N_APP);
    localparam int LW = DW;

    reg_state_t    state_q, state_d;
    logic [LW-1:0] len_shadow_q;
    logic          boundary;
    logic          start;
    logic          reload;
    logic          avail;
    logic          run;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT_SYNC;
        end else begin
            state_q <= state_d;
        end
    end

    // next state and outputs
    always_comb begin
        state_d     = state_q;
        start       = 1'b0;
        req_ready_o = 1'b0;
        unique case (state_q)
            ST_WAIT_SYNC: begin
                if (frame_sync_i) begin
                    start   = 1'b1;
                    state_d = ST_RUN;
                end
            end
            ST_RUN: begin
                req_ready_o = avail;
            end
            default: state_d = ST_WAIT_SYNC;
        endcase
        req_hold_o = req_valid_i && !req_ready_o;
    end

    assign run    = (state_q == ST_RUN);
    assign reload = start || boundary;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_shadow_q <= LW'(DEF_LEN);
        end else if (cfg_we_i && cfg_len_sel_i) begin
            len_shadow_q <= cfg_data_i[LW-1:0];
        end
    end

    bwreg_frame_timer #(
        .LW      (LW),
        .DEF_LEN (DEF_LEN)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .run_i        (run),
        .len_shadow_i (len_shadow_q),
        .boundary_o   (boundary),
        .first_o      (frame_first_o)
    );

    bwreg_quota_bank #(
        .N_APP (N_APP),
        .QW    (QW),
        .AW    (AW)
    ) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .q_we_i   (cfg_we_i && !cfg_len_sel_i),
        .q_addr_i (cfg_app_i),
        .q_data_i (cfg_data_i[QW-1:0]),
        .reload_i (reload),
        .take_i   (req_valid_i && req_ready_o),
        .app_i    (req_app_i),
        .avail_o  (avail)
    );

    // R1: nothing is granted before the global sync pulse
    p_wait_no_grant_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYNC) |-> (!req_ready_o && !frame_first_o));

    // R1: the sync pulse opens the first frame on the next cycle
    p_sync_starts_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_SYNC && frame_sync_i) |=> frame_first_o);

    // R9: grant and hold never coincide
    p_hold_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready_o && req_hold_o));

    // R5: once running the block never returns to waiting
    p_stay_run_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN) |=> (state_q == ST_RUN));
endmodule

// File: tb/test_bwreg_regulator.sv
module test_bwreg_regulator;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync_i = 1'b0;
    logic        req_valid_i = 1'b0;
    logic [3:0]  req_app_i = '0;
    logic        req_ready_o;
    logic        req_hold_o;
    logic        cfg_we_i = 1'b0;
    logic        cfg_len_sel_i = 1'b0;
    logic [3:0]  cfg_app_i = '0;
    logic [15:0] cfg_data_i = '0;
    logic        frame_first_o;

    always #(CLK_PERIOD/2) clk = ~clk;

    bwreg_regulator i_bwreg_regulator (
        .clk           (clk),
        .rst_n         (rst_n),
        .frame_sync_i  (frame_sync_i),
        .req_valid_i   (req_valid_i),
        .req_app_i     (req_app_i),
        .req_ready_o   (req_ready_o),
        .req_hold_o    (req_hold_o),
        .cfg_we_i      (cfg_we_i),
        .cfg_len_sel_i (cfg_len_sel_i),
        .cfg_app_i     (cfg_app_i),
        .cfg_data_i    (cfg_data_i),
        .frame_first_o (frame_first_o)
    );

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    // reference model
    int m_q [16];
    int m_cnt [16];
    int m_len_sh;
    int m_len;
    int m_tmr;
    bit m_run;
    bit last_grant;
    bit last_first;

    function automatic int eff_len(input int l);
        return (l == 0) ? 1 : l;
    endfunction

    function automatic bit exp_ready(input int app);
        return m_run && (m_cnt[app] != 0);
    endfunction

    task automatic check(input string tag, input string what, input int got, input int exp);
        n_checks++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
        end
    endtask

    task automatic step(input bit v, input int a, input bit s, input bit we,
                        input bit sel, input int ca, input int d, input string tag);
        bit er, bnd, rl;
        @(negedge clk);
        req_valid_i   = v;
        req_app_i     = 4'(a);
        frame_sync_i  = s;
        cfg_we_i      = we;
        cfg_len_sel_i = sel;
        cfg_app_i     = 4'(ca);
        cfg_data_i    = 16'(d);
        #1;
        er = exp_ready(a);
        check(tag, "req_ready_o", int'(req_ready_o), int'(er));
        check("R9", "req_hold_o", int'(req_hold_o), int'(v && !er));
        check("R8", "frame_first_o", int'(frame_first_o), int'(m_run && m_tmr == 0));
        last_grant = v && req_ready_o;
        last_first = frame_first_o;
        // model the coming clock edge
        bnd = m_run && (m_tmr == eff_len(m_len) - 1);
        rl  = (!m_run && s) || bnd;
        if (rl) begin
            for (int i = 0; i < 16; i++) m_cnt[i] = m_q[i];
            m_len = m_len_sh;
            m_tmr = 0;
            m_run = 1'b1;
        end else if (m_run) begin
            m_tmr++;
            if (v && er) m_cnt[a]--;
        end
        if (we) begin
            if (sel) m_len_sh = d & 16'hFFFF;
            else     m_q[ca] = d & 8'hFF;
        end
    endtask

    task automatic idle(input string tag);
        step(1'b0, 0, 1'b0, 1'b0, 1'b0, 0, 0, tag);
    endtask

    task automatic wr(input bit sel, input int ca, input int d, input string tag);
        step(1'b0, 0, 1'b0, 1'b1, sel, ca, d, tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        int grants;
        int firsts;
        int seed;
        seed = 32'h5EED_0042;
        void'($urandom(seed));
        for (int i = 0; i < 16; i++) begin
            m_q[i]   = 0;
            m_cnt[i] = 0;
        end
        m_len_sh = 16; m_len = 16; m_tmr = 0; m_run = 1'b0;

        repeat (3) @(posedge clk);
        #1;
        check("R1", "reset ready", int'(req_ready_o), 0);
        check("R8", "reset first", int'(frame_first_o), 0);
        rst_n = 1'b1;

        // R1: requests before sync are held
        for (int i = 0; i < 6; i++) step(1'b1, i, 1'b0, 1'b0, 1'b0, 0, 0, "R1");

        // configure: app0=3, app1=0, others 2, length 12
        wr(1'b0, 0, 3, "R1");
        wr(1'b0, 1, 0, "R1");
        for (int i = 2; i < 16; i++) wr(1'b0, i, 2, "R1");
        wr(1'b1, 0, 12, "R1");
        step(1'b0, 0, 1'b1, 1'b0, 1'b0, 0, 0, "R1");

        // R3: app0 requests for a whole frame, exactly 3 grants; R5/R8 one first per frame
        grants = 0; firsts = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R3");
            grants += int'(last_grant);
            firsts += int'(last_first);
        end
        check("R3", "grants in frame", grants, 3);
        check("R5", "frame starts in 12 cycles", firsts, 1);

        // R4: quota zero blocks app1 in an otherwise idle frame
        grants = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 1, 1'b0, 1'b0, 1'b0, 0, 0, "R4");
            grants += int'(last_grant);
        end
        check("R4", "grants for zero quota", grants, 0);

        // R7: mid-frame quota write is not used until the next frame
        grants = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 0, 1'b0, (i == 1), 1'b0, 0, 5, "R7");
            grants += int'(last_grant);
        end
        check("R7", "grants before new quota", grants, 3);
        grants = 0;
        for (int i = 0; i < 12; i++) begin
            step(1'b1, 0, 1'b0, 1'b0, 1'b0, 0, 0, "R7");
            grants += int'(last_grant);
        end
        check("R7", "grants after new quota", grants, 5);

        // random traffic with occasional configuration writes
        for (int i = 0; i < 4000; i++) begin
            bit we;
            bit sel;
            we  = ($urandom_range(0, 39) == 0);
            sel = ($urandom_range(0, 3) == 0);
            step($urandom_range(0, 3) != 0, $urandom_range(0, 15), 1'b0, we, sel,
                 $urandom_range(0, 15), sel ? $urandom_range(0, 30) : $urandom_range(0, 6),
                 "R2/R6");
        end

        // R10: length zero makes every cycle a frame start
        wr(1'b1, 0, 0, "R10");
        for (int i = 0; i < 40; i++) idle("R10");
        firsts = 0;
        for (int i = 0; i < 10; i++) begin
            step(1'b1, 2, 1'b0, 1'b0, 1'b0, 0, 0, "R10");
            firsts += int'(last_first);
        end
        check("R10", "first in every cycle", firsts, 10);

        finish_run();
    end
endmodule